// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital half of an integrating analog-to-digital converter. It leaves the integrator, its switches and the zero-crossing comparator outside, and it sequences the whole conversion. A start request opens a discharge phase of fixed length that empties the integrator. A run-up phase follows, in which the unknown input drives the integrator for a programmed number of clocks. Then comes a run-down phase, in which a reference of opposite polarity is switched in and the block counts clocks until the comparator reports that the integrator has reached zero.

The run-down count is the conversion result. The input equals the reference times the run-down count divided by the run-up count. A longer run-up therefore gives more counts per volt and finer resolution, and a shorter one gives a quicker conversion. The comparator output is asynchronous to the block clock, so it passes through a two-flop synchronizer before the sequencer acts on it. If the count reaches a ceiling before zero is reached, the block abandons the conversion and flags an overrange.

Top module: `dsadc_ctrl`

## Requirements
- R1: While and after reset, before any start, all three switch selects are low, `done_o` and `ovr_o` are low and `result_o` is 0.
- R2: A high `start_i` sampled while idle raises `sw_zero_o` in the next cycle. It stays high for exactly ZERO_CYC cycles, and it is the only select high during that time.
- R3: Right after the discharge phase, `sw_in_o` is high for exactly N cycles, where N is `runup_len_i` captured on the accepted start. A captured value of 0 is treated as 1.
- R4: `sw_ref_o` rises in the cycle after `sw_in_o` falls and stays high until the conversion ends. No two switch selects are ever high together.
- R5: Let E0 be the rising edge after which `sw_ref_o` is first high. If `cmp_i` is driven low after the D-th rising edge that follows E0 (D = 0 means right after E0), and D+2 <= MAX_CNT, then `result_o` becomes D+2. The 2 is the synchronizer delay. If `cmp_i` was already low before run-down began, the result is 0.
- R6: `done_o` is high for exactly one cycle, which is the cycle in which the new `result_o` first appears. In every cycle without `done_o`, `result_o` keeps its previous value.
- R7: If the synchronized comparator is still high when the run-down count equals MAX_CNT, the block returns to idle. In that case `ovr_o` is set, `done_o` does not pulse and `result_o` is unchanged. `ovr_o` stays set until the next accepted start, and it reads low in the cycle after that start. The largest result delivered is MAX_CNT.
- R8: A `start_i` pulse during a conversion, together with any change of `runup_len_i`, has no effect on phase lengths or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, honoured only while idle |
| runup_len_i | input | CNT_W | Run-up length in clocks, captured at start |
| cmp_i | input | 1 | Asynchronous comparator, high while integrator output is above zero |
| sw_zero_o | output | 1 | Integrator discharge switch select |
| sw_in_o | output | 1 | Unknown-input switch select |
| sw_ref_o | output | 1 | Reference switch select |
| result_o | output | CNT_W | Last run-down count |
| done_o | output | 1 | One-cycle strobe on a new result |
| ovr_o | output | 1 | Overrange flag, held until the next start |

## Verification
The assertions assume that the comparator changes only at phase-appropriate times: it holds one level over run-up, and during run-down it falls once and does not rise again before the conversion ends. The bench plays an integrator model. It holds `cmp_i` high from the start and drops it once, after a run-down delay computed from the run-up length and an input-to-reference ratio, so every comparator transition is a single clean fall. Where `cmp_i` is held low for the whole conversion, it is set before the start and left unchanged, which keeps the assumption intact.

// File: rtl/dsadc_pkg.sv
`timescale 1ns/1ps
package dsadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ZERO  = 2'd1,
        PH_RUNUP = 2'd2,
        PH_RUNDN = 2'd3
    } phase_t;

    typedef struct packed {
        logic zero;
        logic inp;
        logic vref;
    } sw_sel_t;

    function automatic sw_sel_t sw_decode(input phase_t ph);
        sw_sel_t s;
        s.zero = (ph == PH_ZERO);
        s.inp  = (ph == PH_RUNUP);
        s.vref = (ph == PH_RUNDN);
        return s;
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
`timescale 1ns/1ps
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dsadc_seq.sv
`timescale 1ns/1ps
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int ZERO_CYC = 16,
    parameter int MAX_CNT  = 4000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] runup_len_i,
    input  logic             cmp_s_i,
    output phase_t           phase_o,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o,
    output logic             ovr_o
);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO_LAST = CNT_W'(ZERO_CYC - 1);
    localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(MAX_CNT);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] upl;
    logic [CNT_W-1:0] res;
    logic             done;
    logic             ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            upl  <= ONE;
            res  <= '0;
            done <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start_i) begin
                        ph  <= PH_ZERO;
                        cnt <= '0;
                        upl <= (runup_len_i == '0) ? ONE : runup_len_i;
                        ovr <= 1'b0;
                    end
                end
                PH_ZERO: begin
                    if (cnt == ZERO_LAST) begin
                        ph  <= PH_RUNUP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_RUNUP: begin
                    if (cnt == upl - ONE) begin
                        ph  <= PH_RUNDN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_RUNDN: begin
                    if (!cmp_s_i) begin
                        res  <= cnt;
                        done <= 1'b1;
                        ph   <= PH_IDLE;
                    end else if (cnt == MAX_LAST) begin
                        ovr <= 1'b1;
                        ph  <= PH_IDLE;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign phase_o  = ph;
    assign result_o = res;
    assign done_o   = done;
    assign ovr_o    = ovr;

    // R6: strobe lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: result held between strobes
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(res));
    // R7: run-down count never passes the ceiling
    p_count_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RUNDN) |-> (cnt <= MAX_LAST));
    // R7: overrange only ends a run-down, never with a strobe
    p_ovr_from_rundn_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> (!done && $past(ph == PH_RUNDN)));
    // R8: a request in run-up does not restart the sequence
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RUNUP && start_i) |=> (ph != PH_ZERO));
endmodule

// File: rtl/dsadc_ctrl.sv
`timescale 1ns/1ps
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int ZERO_CYC  = 16,
    parameter int MAX_CNT   = 4000,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] runup_len_i,
    input  logic             cmp_i,
    output logic             sw_zero_o,
    output logic             sw_in_o,
    output logic             sw_ref_o,
    output logic [CNT_W-1:0] result_o,
    output logic             done_o,
    output logic             ovr_o
);
    logic    cmp_s;
    phase_t  phase;
    sw_sel_t sel;

    dsadc_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    dsadc_seq #(
        .CNT_W    (CNT_W),
        .ZERO_CYC (ZERO_CYC),
        .MAX_CNT  (MAX_CNT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .runup_len_i (runup_len_i),
        .cmp_s_i     (cmp_s),
        .phase_o     (phase),
        .result_o    (result_o),
        .done_o      (done_o),
        .ovr_o       (ovr_o)
    );

    assign sel       = sw_decode(phase);
    assign sw_zero_o = sel.zero;
    assign sw_in_o   = sel.inp;
    assign sw_ref_o  = sel.vref;

    // R4: switch selects never overlap
    p_sw_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sw_zero_o, sw_in_o, sw_ref_o}));
    // R3: run-up directly follows discharge
    p_in_after_zero_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_in_o) |-> $past(sw_zero_o));
    // R4: run-down directly follows run-up
    p_ref_after_in_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_ref_o) |-> $past(sw_in_o));
    // R6: a strobe only closes a run-down
    p_done_after_ref_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(sw_ref_o) && !sw_ref_o));
endmodule

// File: tb/dsadc_ctrl_test.sv
`timescale 1ns/1ps
module dsadc_ctrl_test;
    localparam int CNT_W = 6;
    localparam int ZC    = 3;
    localparam int MAXC  = 40;
    localparam int VREF  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] runup_len_i = '0;
    logic             cmp_i = 1'b1;
    logic             sw_zero_o, sw_in_o, sw_ref_o, done_o, ovr_o;
    logic [CNT_W-1:0] result_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dsadc_ctrl #(
        .CNT_W    (CNT_W),
        .ZERO_CYC (ZC),
        .MAX_CNT  (MAXC)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .runup_len_i (runup_len_i),
        .cmp_i       (cmp_i),
        .sw_zero_o   (sw_zero_o),
        .sw_in_o     (sw_in_o),
        .sw_ref_o    (sw_ref_o),
        .result_o    (result_o),
        .done_o      (done_o),
        .ovr_o       (ovr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; d = run-down delay, early = comparator low from the start,
    // poke = extra request and length change during run-up, expect_ovr = overrange case.
    task automatic run_conv(input int n, input int d, input bit early,
                            input bit poke, input bit expect_ovr);
        int zc = 0;
        int ic = 0;
        int guard = 0;
        int prev_res;
        int nn;
        bit got_done = 0;
        bit poked = 0;
        nn = (n == 0) ? 1 : n;
        prev_res = int'(result_o);
        @(negedge clk);
        runup_len_i = CNT_W'(n);
        cmp_i   = early ? 1'b0 : 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(ovr_o == 1'b0, "R7 flag clear after start", int'(ovr_o), 0);
        chk(sw_zero_o == 1'b1, "R2 discharge begins", int'(sw_zero_o), 1);
        while (!sw_ref_o && guard < 500) begin
            if (sw_zero_o) zc++;
            if (sw_in_o) begin
                ic++;
                if (poke && !poked) begin
                    start_i = 1'b1;
                    runup_len_i = CNT_W'(n + 5);
                    poked = 1;
                end else begin
                    start_i = 1'b0;
                end
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        chk(zc == ZC, "R2 discharge length", zc, ZC);
        chk(ic == nn, poke ? "R8 run-up length kept" : "R3 run-up length", ic, nn);
        chk(sw_ref_o == 1'b1, "R4 reference phase entered", int'(sw_ref_o), 1);
        if (!early) begin
            repeat (d) @(negedge clk);
            cmp_i = 1'b0;
        end
        guard = 0;
        while (guard < 200) begin
            if (done_o) got_done = 1;
            if (!sw_ref_o) break;
            @(negedge clk);
            guard++;
        end
        if (expect_ovr) begin
            chk(got_done == 0, "R7 no strobe on overrange", int'(got_done), 0);
            chk(ovr_o == 1'b1, "R7 overrange flag", int'(ovr_o), 1);
            chk(int'(result_o) == prev_res, "R7 result unchanged", int'(result_o), prev_res);
        end else begin
            chk(got_done == 1, "R6 strobe with result", int'(got_done), 1);
            chk(int'(result_o) == (early ? 0 : d + 2),
                early ? "R5 early zero result" : (poke ? "R8 result" : "R5 result"),
                int'(result_o), early ? 0 : d + 2);
            chk(ovr_o == 1'b0, "R7 no overrange", int'(ovr_o), 0);
            prev_res = int'(result_o);
            @(negedge clk);
            chk(done_o == 1'b0, "R6 strobe one cycle", int'(done_o), 0);
            chk(int'(result_o) == prev_res, "R6 result held", int'(result_o), prev_res);
        end
        cmp_i = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({sw_zero_o, sw_in_o, sw_ref_o} == 3'b000, "R1 selects low", int'({sw_zero_o, sw_in_o, sw_ref_o}), 0);
        chk(done_o == 1'b0 && ovr_o == 1'b0, "R1 flags low", int'({done_o, ovr_o}), 0);
        chk(result_o == '0, "R1 result zero", int'(result_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({sw_zero_o, sw_in_o, sw_ref_o} == 3'b000, "R1 idle after reset", int'({sw_zero_o, sw_in_o, sw_ref_o}), 0);

        // R3, R5: sweep run-up length and input-to-reference ratio
        for (int n = 0; n <= 6; n++) begin
            for (int vin = 0; vin <= 7; vin++) begin
                int nn = (n == 0) ? 1 : n;
                run_conv(n, (nn * vin + VREF - 1) / VREF, 1'b0, 1'b0, 1'b0);
            end
        end
        // R5: comparator already low
        run_conv(3, 0, 1'b1, 1'b0, 1'b0);
        // R8: request and length change inside run-up
        run_conv(4, 5, 1'b0, 1'b1, 1'b0);
        // R7: largest accepted count
        run_conv(2, MAXC - 2, 1'b0, 1'b0, 1'b0);
        // R7: one beyond the ceiling
        run_conv(2, MAXC - 1, 1'b0, 1'b0, 1'b1);
        // R7: flag cleared on the next start, normal result follows
        run_conv(5, 3, 1'b0, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule